// File: doc/BRIEF.md
# Interrupt source state and redelivery controller

This block keeps the state of a bank of interrupt sources. For each source it holds a target server, a priority, a flag for a rejected delivery and a flag for a trigger that arrived while the source was masked. A trigger event names a source by its local index. If the source is enabled, the block offers a delivery carrying the target server, the global source number and the priority to the presentation layer. A priority of all ones masks the source. A trigger on a masked source is not lost: it is remembered and delivered when software later unmasks the source.

The presentation layer talks back through two inputs. A reject input flags a source whose delivery it could not take. A resend request starts a scan over the whole bank, one source per clock in ascending order, which re-offers every flagged source that is not masked. A configuration port lets software write or read the server and priority of a source by global number, and each access returns a status code. An end-of-interrupt input is accepted and leaves all source state alone.

Top module: `intsrc_redeliver`

## Requirements
- R1: Global number = local index + NUM_BASE (default 16). A global number is valid only when NUM_BASE <= number < NUM_BASE + NUM_SRC. Every delivery carries a global number in that range.
- R2: After reset every source has server 0, priority 0xFF and both flags clear. `busy`, `dlv_valid` and `cfg_rsp_valid` are low.
- R3: A trigger on a source whose priority is 0xFF sets that source's remembered-trigger flag and produces no delivery. No delivery ever carries priority 0xFF.
- R4: A trigger on a source with any other priority raises `dlv_valid` after the next clock edge, with the stored server, the global number and the stored priority.
- R5: A delivery stays valid with an unchanged payload until a clock edge where `dlv_ready` is high.
- R6: A reject with a valid global number sets that source's rejected flag. A reject with an invalid number has no effect.
- R7: A resend request examines the sources in ascending index order, one per clock edge while the delivery register can take a new item. Each flagged source has its flag cleared and is redelivered unless its priority is 0xFF. The scan stalls while an offered delivery is held with `dlv_ready` low. With no flagged sources, `busy` stays high for exactly NUM_SRC cycles.
- R8: A successful configuration write stores the server and the priority. If the source had a remembered trigger and the new priority is not 0xFF, the flag is cleared and a delivery to the new server at the new priority is offered after the same edge.
- R9: A configuration write returns status 0xFD (-3 in 8-bit two's complement) and changes nothing when the number is invalid, when the server is NUM_SRV or above, or when the priority is above 0xFF. Otherwise it returns status 0x00. The response arrives one cycle after the request.
- R10: A configuration read of a valid number returns status 0x00 with the stored server and priority. A read of an invalid number returns status 0xFD.
- R11: An end-of-interrupt input has no effect on any source state.
- R12: `busy` is high while a scan runs or a delivery is held. Triggers, rejects, resend requests and configuration requests are acted on only while `busy` is low, at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger event strobe |
| trig_idx | input | IDX_W | Local index of the triggered source |
| rej_valid | input | 1 | Reject strobe from the presentation layer |
| rej_num | input | GNUM_W | Global number of the rejected source |
| resend_req | input | 1 | Starts a redelivery scan |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | GNUM_W | Global number for the end of interrupt |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_num | input | GNUM_W | Global source number for the access |
| cfg_server | input | SRV_IN_W | Server to write |
| cfg_prio | input | PRIO_W+1 | Priority to write (the extra bit allows out-of-range values) |
| cfg_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| cfg_rsp_status | output | 8 | 0x00 success, 0xFD error |
| cfg_rsp_server | output | SRV_W | Server read back |
| cfg_rsp_prio | output | PRIO_W | Priority read back |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Presentation layer takes the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_num | output | GNUM_W | Global source number of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivery |
| busy | output | 1 | Scan running or delivery held |

## Verification
The assertions assume that the environment presents triggers, rejects, resend requests and configuration requests only while `busy` is low, and never more than one of them in a cycle. The stimulus keeps to this by waiting for `busy` to fall before every operation and issuing operations one at a time. The end-of-interrupt input is not bound by this rule. The bench drives `dlv_ready` from a separate process that can be held high, held low, or varied pseudo-randomly, so held deliveries and scan stalls occur both on purpose and at random.

// File: rtl/isr_pkg.sv
package isr_pkg;
   typedef logic [7:0] status_t;
   localparam status_t ST_OK  = 8'h00;
   localparam status_t ST_BAD = 8'hFD;

   typedef enum logic [1:0] {
      LK_CFG  = 2'd0,
      LK_TRIG = 2'd1,
      LK_SCAN = 2'd2
   } lk_sel_e;
endpackage

// File: rtl/isr_num_check.sv
module isr_num_check #(
   parameter int NUM_SRC  = 16,
   parameter int NUM_BASE = 16,
   parameter int GNUM_W   = 16,
   parameter int IDX_W    = 4
) (
   input  logic [GNUM_W-1:0] num,
   output logic              in_range,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [GNUM_W:0] TOP_EXCL = (GNUM_W+1)'(NUM_BASE + NUM_SRC);
   localparam logic [GNUM_W-1:0] BASE_V = GNUM_W'(NUM_BASE);

   logic [GNUM_W-1:0] diff;
   assign diff = num - BASE_V;
   assign idx  = diff[IDX_W-1:0];

   generate
      if (NUM_BASE == 0) begin : g_zero_base
         assign in_range = {1'b0, num} < TOP_EXCL;
      end else begin : g_offset_base
         assign in_range = (num >= BASE_V) && ({1'b0, num} < TOP_EXCL);
      end
   endgenerate
endmodule

// File: rtl/isr_src_table.sv
module isr_src_table #(
   parameter int NUM_SRC = 16,
   parameter int IDX_W   = 4,
   parameter int SRV_W   = 2,
   parameter int PRIO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic [SRV_W-1:0]  lk_srv,
   output logic [PRIO_W-1:0] lk_prio,
   output logic              lk_rej,
   output logic              lk_mp,
   input  logic              set_mp,
   input  logic              clr_rej,
   input  logic              wr_en,
   input  logic              wr_clr_mp,
   input  logic [SRV_W-1:0]  wr_srv,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic              mark_rej,
   input  logic [IDX_W-1:0]  mark_idx
);
   localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

   logic [SRV_W-1:0]  srv_q  [NUM_SRC];
   logic [PRIO_W-1:0] prio_q [NUM_SRC];
   logic [NUM_SRC-1:0] rej_q;
   logic [NUM_SRC-1:0] mp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            srv_q[i]  <= '0;
            prio_q[i] <= PRIO_OFF;
         end
         rej_q <= '0;
         mp_q  <= '0;
      end else begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (IDX_W'(i) == lk_idx) begin
               if (wr_en) begin
                  srv_q[i]  <= wr_srv;
                  prio_q[i] <= wr_prio;
               end
               if (set_mp) begin
                  mp_q[i] <= 1'b1;
               end else if (wr_clr_mp) begin
                  mp_q[i] <= 1'b0;
               end
               if (clr_rej) begin
                  rej_q[i] <= 1'b0;
               end
            end
            if (mark_rej && (IDX_W'(i) == mark_idx)) begin
               rej_q[i] <= 1'b1;
            end
         end
      end
   end

   assign lk_srv  = srv_q[lk_idx];
   assign lk_prio = prio_q[lk_idx];
   assign lk_rej  = rej_q[lk_idx];
   assign lk_mp   = mp_q[lk_idx];

   // R6 / R7: a flag is never set and cleared on the same edge
   p_rej_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_rej && mark_rej));
endmodule

// File: rtl/isr_scan.sv
module isr_scan #(
   parameter int NUM_SRC = 16,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   output logic             active,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         ptr    <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         ptr    <= '0;
      end else if (active && step) begin
         if (ptr == LAST) begin
            active <= 1'b0;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end

   // R7: ascending order, one source per advancing edge
   p_scan_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && ptr != LAST) |=> (active && ptr == $past(ptr) + 1'b1));
   // R7: a stalled scan keeps its place
   p_scan_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !step) |=> (active && $stable(ptr)));
   // R7: the scan ends after the last source
   p_scan_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && ptr == LAST) |=> !active);
endmodule

// File: rtl/isr_dlv_reg.sv
module isr_dlv_reg #(
   parameter int SRV_W  = 2,
   parameter int GNUM_W = 16,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SRV_W-1:0]  in_srv,
   input  logic [GNUM_W-1:0] in_num,
   input  logic [PRIO_W-1:0] in_prio,
   output logic              valid,
   input  logic              ready,
   output logic [SRV_W-1:0]  out_srv,
   output logic [GNUM_W-1:0] out_num,
   output logic [PRIO_W-1:0] out_prio
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         out_srv  <= '0;
         out_num  <= '0;
         out_prio <= '0;
      end else if (load) begin
         valid    <= 1'b1;
         out_srv  <= in_srv;
         out_num  <= in_num;
         out_prio <= in_prio;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R5: a held delivery keeps its payload
   p_dlv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(out_srv) && $stable(out_num) && $stable(out_prio)));
   // R5: nothing overwrites a delivery that has not been taken
   p_dlv_no_clobber_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!valid || ready));
endmodule

// File: rtl/intsrc_redeliver.sv
module intsrc_redeliver
   import isr_pkg::*;
#(
   parameter int NUM_SRC  = 16,
   parameter int NUM_SRV  = 4,
   parameter int NUM_BASE = 16,
   parameter int GNUM_W   = 16,
   parameter int PRIO_W   = 8,
   parameter int SRV_IN_W = 8,
   localparam int IDX_W   = $clog2(NUM_SRC),
   localparam int SRV_W   = $clog2(NUM_SRV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [IDX_W-1:0]  trig_idx,
   input  logic              rej_valid,
   input  logic [GNUM_W-1:0] rej_num,
   input  logic              resend_req,
   input  logic              eoi_valid,
   input  logic [GNUM_W-1:0] eoi_num,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [GNUM_W-1:0] cfg_num,
   input  logic [SRV_IN_W-1:0] cfg_server,
   input  logic [PRIO_W:0]   cfg_prio,
   output logic              cfg_rsp_valid,
   output logic [7:0]        cfg_rsp_status,
   output logic [SRV_W-1:0]  cfg_rsp_server,
   output logic [PRIO_W-1:0] cfg_rsp_prio,
   output logic              dlv_valid,
   input  logic              dlv_ready,
   output logic [SRV_W-1:0]  dlv_server,
   output logic [GNUM_W-1:0] dlv_num,
   output logic [PRIO_W-1:0] dlv_prio,
   output logic              busy
);
   localparam logic [PRIO_W-1:0] PRIO_OFF = '1;
   localparam logic [GNUM_W-1:0] BASE_V   = GNUM_W'(NUM_BASE);

   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("NUM_SRC must be at least 2");
      end
      if (NUM_SRV < 2 || NUM_SRV > (1 << SRV_IN_W)) begin : g_bad_srv
         $error("NUM_SRV must lie in 2 .. 2**SRV_IN_W");
      end
      if (NUM_BASE + NUM_SRC > (1 << GNUM_W)) begin : g_bad_num
         $error("global numbers do not fit GNUM_W");
      end
   endgenerate

   // operation acceptance
   logic trig_go, rej_go, resend_go, cfg_go;
   assign trig_go   = trig_valid && !busy && ({1'b0, trig_idx} < (IDX_W+1)'(NUM_SRC));
   assign rej_go    = rej_valid  && !busy;
   assign resend_go = resend_req && !busy;
   assign cfg_go    = cfg_req    && !busy;

   // number decoding
   logic             rej_ok, cfg_in_range;
   logic [IDX_W-1:0] rej_idx, cfg_idx;

   isr_num_check #(.NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .GNUM_W(GNUM_W), .IDX_W(IDX_W))
      u_rej_chk (.num(rej_num), .in_range(rej_ok), .idx(rej_idx));
   isr_num_check #(.NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .GNUM_W(GNUM_W), .IDX_W(IDX_W))
      u_cfg_chk (.num(cfg_num), .in_range(cfg_in_range), .idx(cfg_idx));

   // scanner
   logic             scan_active, scan_step, can_load;
   logic [IDX_W-1:0] scan_ptr;

   isr_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(resend_go), .step(scan_step),
      .active(scan_active), .ptr(scan_ptr));

   // single lookup port into the table
   lk_sel_e          lk_sel;
   logic [IDX_W-1:0] lk_idx;
   logic [SRV_W-1:0] lk_srv;
   logic [PRIO_W-1:0] lk_prio;
   logic             lk_rej, lk_mp;

   always_comb begin
      if (scan_active)  lk_sel = LK_SCAN;
      else if (trig_go) lk_sel = LK_TRIG;
      else              lk_sel = LK_CFG;
      unique case (lk_sel)
         LK_SCAN: lk_idx = scan_ptr;
         LK_TRIG: lk_idx = trig_idx;
         default: lk_idx = cfg_idx;
      endcase
   end

   // decisions
   logic cfg_ok, wr_go, cfg_fire, set_mp, trig_fire, scan_fire, clr_rej, dlv_load;
   logic lk_masked;

   assign lk_masked = (lk_prio == PRIO_OFF);
   assign can_load  = !dlv_valid || dlv_ready;
   assign scan_step = scan_active && can_load;
   assign cfg_ok    = cfg_in_range
                    && ({1'b0, cfg_server} < (SRV_IN_W+1)'(NUM_SRV))
                    && (cfg_prio <= {1'b0, PRIO_OFF});
   assign wr_go     = cfg_go && cfg_we && cfg_ok;
   assign cfg_fire  = wr_go && lk_mp && (cfg_prio[PRIO_W-1:0] != PRIO_OFF);
   assign set_mp    = trig_go && lk_masked;
   assign trig_fire = trig_go && !lk_masked;
   assign clr_rej   = scan_step && lk_rej;
   assign scan_fire = clr_rej && !lk_masked;
   assign dlv_load  = cfg_fire || trig_fire || scan_fire;

   isr_src_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_tab (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(lk_idx), .lk_srv(lk_srv), .lk_prio(lk_prio), .lk_rej(lk_rej), .lk_mp(lk_mp),
      .set_mp(set_mp), .clr_rej(clr_rej),
      .wr_en(wr_go), .wr_clr_mp(cfg_fire),
      .wr_srv(cfg_server[SRV_W-1:0]), .wr_prio(cfg_prio[PRIO_W-1:0]),
      .mark_rej(rej_go && rej_ok), .mark_idx(rej_idx));

   // delivery payload
   logic [SRV_W-1:0]  ld_srv;
   logic [GNUM_W-1:0] ld_num;
   logic [PRIO_W-1:0] ld_prio;

   always_comb begin
      if (cfg_fire) begin
         ld_srv  = cfg_server[SRV_W-1:0];
         ld_num  = cfg_num;
         ld_prio = cfg_prio[PRIO_W-1:0];
      end else begin
         ld_srv  = lk_srv;
         ld_num  = GNUM_W'(lk_idx) + BASE_V;
         ld_prio = lk_prio;
      end
   end

   isr_dlv_reg #(.SRV_W(SRV_W), .GNUM_W(GNUM_W), .PRIO_W(PRIO_W)) u_dlv (
      .clk(clk), .rst_n(rst_n), .load(dlv_load),
      .in_srv(ld_srv), .in_num(ld_num), .in_prio(ld_prio),
      .valid(dlv_valid), .ready(dlv_ready),
      .out_srv(dlv_server), .out_num(dlv_num), .out_prio(dlv_prio));

   assign busy = scan_active || dlv_valid;

   // configuration response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rsp_valid  <= 1'b0;
         cfg_rsp_status <= ST_OK;
         cfg_rsp_server <= '0;
         cfg_rsp_prio   <= '0;
      end else begin
         cfg_rsp_valid <= cfg_go;
         if (cfg_go) begin
            if (cfg_we) begin
               cfg_rsp_status <= cfg_ok ? ST_OK : ST_BAD;
               cfg_rsp_server <= '0;
               cfg_rsp_prio   <= '0;
            end else begin
               cfg_rsp_status <= cfg_in_range ? ST_OK : ST_BAD;
               cfg_rsp_server <= cfg_in_range ? lk_srv  : '0;
               cfg_rsp_prio   <= cfg_in_range ? lk_prio : '0;
            end
         end
      end
   end

   // R11: the end-of-interrupt strobe is taken and has no consumer
   logic eoi_seen;
   assign eoi_seen = eoi_valid && (eoi_num != '1);

   // R12: at most one operation per cycle (input contract)
   p_one_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trig_valid, rej_valid, resend_req, cfg_req}));
   // R12: no operation is presented while busy (input contract)
   p_idle_ops_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(trig_valid || rej_valid || resend_req || cfg_req));
   // R9: every accepted access is answered on the next cycle
   p_cfg_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_go |=> cfg_rsp_valid);
   // R10: only the two status codes appear
   p_status_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rsp_valid |-> (cfg_rsp_status == ST_OK || cfg_rsp_status == ST_BAD));
   // R3: a masked priority never leaves the block
   p_dlv_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_prio != PRIO_OFF));
   // R1: delivered numbers lie in the valid window
   p_dlv_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_num >= BASE_V && {1'b0, dlv_num} < (GNUM_W+1)'(NUM_BASE + NUM_SRC)));
   // R4: a trigger on an enabled source is offered after the edge
   p_trig_dlv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_go && !lk_masked) |=> dlv_valid);
   // R11: an end of interrupt alone never starts a delivery or scan
   p_eoi_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_seen && !busy && !trig_valid && !resend_req && !cfg_req) |=> !busy);
endmodule

// File: tb/intsrc_redeliver_tb_top.sv
module intsrc_redeliver_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 16;
   localparam int NSRV  = 4;
   localparam int BASE  = 16;

   typedef struct packed {
      logic [1:0]  srv;
      logic [15:0] num;
      logic [7:0]  prio;
   } dlv_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_valid = 1'b0;
   logic [3:0] trig_idx = '0;
   logic rej_valid = 1'b0;
   logic [15:0] rej_num = '0;
   logic resend_req = 1'b0;
   logic eoi_valid = 1'b0;
   logic [15:0] eoi_num = '0;
   logic cfg_req = 1'b0, cfg_we = 1'b0;
   logic [15:0] cfg_num = '0;
   logic [7:0] cfg_server = '0;
   logic [8:0] cfg_prio = '0;
   logic cfg_rsp_valid;
   logic [7:0] cfg_rsp_status;
   logic [1:0] cfg_rsp_server;
   logic [7:0] cfg_rsp_prio;
   logic dlv_valid;
   logic dlv_ready = 1'b1;
   logic [1:0] dlv_server;
   logic [15:0] dlv_num;
   logic [7:0] dlv_prio;
   logic busy;

   intsrc_redeliver dut_i (
      .clk(clk), .rst_n(rst_n),
      .trig_valid(trig_valid), .trig_idx(trig_idx),
      .rej_valid(rej_valid), .rej_num(rej_num),
      .resend_req(resend_req),
      .eoi_valid(eoi_valid), .eoi_num(eoi_num),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_num(cfg_num),
      .cfg_server(cfg_server), .cfg_prio(cfg_prio),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_status(cfg_rsp_status),
      .cfg_rsp_server(cfg_rsp_server), .cfg_rsp_prio(cfg_rsp_prio),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
      .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
      .busy(busy));

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference model, built from the requirements
   logic [1:0] m_srv  [N];
   logic [7:0] m_prio [N];
   bit         m_rej  [N];
   bit         m_mp   [N];
   dlv_t exp_q[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ready driver: 0 always high, 1 pseudo-random, 2 held low
   int rdy_mode = 0;
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      case (rdy_mode)
         0: dlv_ready <= 1'b1;
         1: dlv_ready <= ($urandom % 3) != 0;
         default: dlv_ready <= 1'b0;
      endcase
   end

   // monitor: scoreboard pop on every completed handshake, R5 hold check
   bit   prev_hold = 0;
   dlv_t prev_pl;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold) begin
            chk(dlv_valid && ({dlv_server, dlv_num, dlv_prio} == prev_pl), "R5 held delivery",
                {dlv_valid, dlv_server, dlv_num, dlv_prio}, {1'b1, prev_pl});
         end
         if (dlv_valid && dlv_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected delivery", {dlv_server, dlv_num, dlv_prio}, 0);
            end else begin
               dlv_t e;
               e = exp_q.pop_front();
               chk({dlv_server, dlv_num, dlv_prio} == e, "R4/R7 delivery payload",
                   {dlv_server, dlv_num, dlv_prio}, e);
            end
         end
         prev_hold = dlv_valid && !dlv_ready;
         prev_pl   = {dlv_server, dlv_num, dlv_prio};
      end
   end

   function automatic bit num_valid(input int num);
      return (num >= BASE) && (num < BASE + N);
   endfunction

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic do_trig(input int idx);
      dlv_t e;
      bit   fire;
      wait_idle();
      trig_valid = 1'b1;
      trig_idx   = 4'(idx);
      fire = (m_prio[idx] != 8'hFF);
      if (fire) begin
         e = '{srv: m_srv[idx], num: 16'(idx + BASE), prio: m_prio[idx]};
         exp_q.push_back(e);
      end else begin
         m_mp[idx] = 1;
      end
      @(negedge clk);
      trig_valid = 1'b0;
      if (fire) chk(dlv_valid == 1'b1, "R4 delivery one cycle after trigger", dlv_valid, 1);
      else      chk(dlv_valid == 1'b0, "R3 masked trigger not delivered", dlv_valid, 0);
   endtask

   task automatic do_rej(input int num);
      wait_idle();
      rej_valid = 1'b1;
      rej_num   = 16'(num);
      if (num_valid(num)) m_rej[num - BASE] = 1;
      @(negedge clk);
      rej_valid = 1'b0;
   endtask

   task automatic do_eoi(input int num);
      eoi_valid = 1'b1;
      eoi_num   = 16'(num);
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic do_resend(output int busy_cycles);
      wait_idle();
      for (int i = 0; i < N; i++) begin
         if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_prio[i] != 8'hFF)
               exp_q.push_back('{srv: m_srv[i], num: 16'(i + BASE), prio: m_prio[i]});
         end
      end
      resend_req = 1'b1;
      @(negedge clk);
      resend_req = 1'b0;
      busy_cycles = 0;
      while (busy) begin
         busy_cycles++;
         @(negedge clk);
      end
   endtask

   task automatic do_cfg(input bit we, input int num, input int srv, input int prio, input string tag);
      bit ok;
      bit fire = 0;
      wait_idle();
      cfg_req    = 1'b1;
      cfg_we     = we;
      cfg_num    = 16'(num);
      cfg_server = 8'(srv);
      cfg_prio   = 9'(prio);
      if (we) begin
         ok = num_valid(num) && (srv < NSRV) && (prio <= 255);
         if (ok) begin
            m_srv[num - BASE]  = 2'(srv);
            m_prio[num - BASE] = 8'(prio);
            if (m_mp[num - BASE] && prio != 255) begin
               m_mp[num - BASE] = 0;
               fire = 1;
               exp_q.push_back('{srv: 2'(srv), num: 16'(num), prio: 8'(prio)});
            end
         end
      end else begin
         ok = num_valid(num);
      end
      @(negedge clk);
      cfg_req = 1'b0;
      chk(cfg_rsp_valid == 1'b1, {tag, " response strobe"}, cfg_rsp_valid, 1);
      chk(cfg_rsp_status == (ok ? 8'h00 : 8'hFD), {tag, " status"}, cfg_rsp_status, ok ? 8'h00 : 8'hFD);
      if (!we && ok) begin
         chk(cfg_rsp_server == m_srv[num - BASE], {tag, " read server"}, cfg_rsp_server, m_srv[num - BASE]);
         chk(cfg_rsp_prio == m_prio[num - BASE], {tag, " read priority"}, cfg_rsp_prio, m_prio[num - BASE]);
      end
      if (fire) chk(dlv_valid == 1'b1, "R8 unmask delivers", dlv_valid, 1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int bc;
      for (int i = 0; i < N; i++) begin
         m_srv[i] = 0; m_prio[i] = 8'hFF; m_rej[i] = 0; m_mp[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(busy == 1'b0, "R2 busy after reset", busy, 0);
      chk(dlv_valid == 1'b0, "R2 no delivery after reset", dlv_valid, 0);
      chk(cfg_rsp_valid == 1'b0, "R2 no response after reset", cfg_rsp_valid, 0);
      for (int i = 0; i < N; i++) do_cfg(0, BASE + i, 0, 0, "R2 reset read");

      // R3 masked trigger remembered, R8 unmask delivers to new target
      do_trig(0);
      do_cfg(1, BASE + 0, 2, 5, "R8 unmask write");
      do_trig(0);                     // R4 now enabled
      do_cfg(1, BASE + 3, 1, 8'hFF, "R8 write keeping mask");
      do_trig(3);
      do_cfg(1, BASE + 3, 1, 8'hFF, "R8 masked rewrite no delivery");
      do_cfg(1, BASE + 3, 3, 9, "R8 late unmask");

      // R1 / R9 / R10 boundaries
      do_cfg(1, BASE - 1, 0, 1, "R9 number below base");
      do_cfg(1, BASE + N, 0, 1, "R9 number past end");
      do_cfg(1, BASE + 1, NSRV, 1, "R9 server out of range");
      do_cfg(1, BASE + 1, 0, 256, "R9 priority above 0xFF");
      do_cfg(0, BASE + 1, 0, 0, "R9 state unchanged after errors");
      do_cfg(1, BASE + N - 1, NSRV - 1, 0, "R1 last valid number");
      do_cfg(0, BASE + N - 1, 0, 0, "R10 read last");
      do_cfg(0, BASE - 1, 0, 0, "R10 read invalid low");
      do_cfg(0, BASE + N, 0, 0, "R10 read invalid high");
      do_trig(N - 1);

      // R7 empty scan takes NUM_SRC cycles
      do_resend(bc);
      chk(bc == N, "R7 empty scan length", bc, N);

      // R6 / R7 / R11 rejects, ascending replay, masked rejected source
      do_cfg(1, BASE + 1, 1, 3, "R6 setup");
      do_cfg(1, BASE + 9, 2, 7, "R6 setup");
      do_rej(BASE + 9);
      do_rej(BASE + 1);
      do_rej(BASE + 5);               // priority 0xFF, cleared but not sent
      do_rej(BASE + 40);              // R6 invalid ignored
      do_rej(BASE - 2);
      do_eoi(BASE + 9);               // R11 no effect
      do_eoi(BASE + 1);
      do_cfg(0, BASE + 9, 0, 0, "R11 state after end of interrupt");
      do_resend(bc);
      chk(exp_q.size() == 0, "R7 replay drained", exp_q.size(), 0);
      do_cfg(1, BASE + 5, 0, 4, "R7 unmask after cleared reject");
      do_resend(bc);
      chk(bc == N, "R7 flags cleared by previous scan", bc, N);

      // R5 / R7 stall with ready held low
      do_rej(BASE + 0);
      do_rej(BASE + 9);
      rdy_mode = 2;
      wait_idle();
      resend_req = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_prio[i] != 8'hFF)
               exp_q.push_back('{srv: m_srv[i], num: 16'(i + BASE), prio: m_prio[i]});
         end
      end
      @(negedge clk);
      resend_req = 1'b0;
      repeat (N + 4) @(negedge clk);
      chk(busy == 1'b1, "R7 scan stalls while ready low", busy, 1);
      chk(dlv_valid && dlv_num == 16'(BASE + 0), "R7 first replay held", dlv_num, BASE + 0);
      rdy_mode = 0;
      wait_idle();
      chk(exp_q.size() == 0, "R7 stalled replay drained", exp_q.size(), 0);

      // R12 operations interleaved with random ready
      rdy_mode = 1;
      for (int k = 0; k < 300; k++) begin
         int op = $urandom % 6;
         int n  = BASE - 2 + ($urandom % (N + 4));
         case (op)
            0, 1: do_trig($urandom % N);
            2: do_rej(n);
            3: do_resend(bc);
            4: do_cfg(1, n, $urandom % (NSRV + 1), ($urandom % 4 == 0) ? 255 : $urandom % 300, "R8/R9 random write");
            default: do_cfg(0, n, 0, 0, "R10 random read");
         endcase
         if ($urandom % 5 == 0) do_eoi(n);
      end
      rdy_mode = 0;
      wait_idle();
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R12 all expected deliveries seen", exp_q.size(), 0);
      finish_run();
   end
endmodule